// File: doc/BRIEF.md
# DTMF Steering and Key Latch Controller

This block sits behind a dual-tone frequency classifier. The classifier supplies a flag that says a valid row/column tone pair is present, together with the 2-bit row and column indices. The block turns that flag into an early-steering signal. It qualifies the tone with two digital guard timers, which take the place of an external RC network. When a tone is accepted, the block latches a 4-bit key code and raises a data-valid strobe.

A tone is accepted only after early-steering has stayed high for a full presence guard window. A tone is released only after early-steering has stayed low for a full absence guard window. Both windows are parameters counted in clock ticks. The host sets them so that bursts and gaps shorter than about 20 ms are rejected and those of 42 ms or more are accepted. The key code is stable before data-valid rises, and it stays on the bus after data-valid falls. An output-enable flag stands in for a tristate pad. A power-down input stops detection.

The asynchronous active-low reset is released through a two-stage synchronizer, so the core leaves reset on the second clock edge after `rst_n` goes high.

Top module: `dtmf_steer_ctrl`

## Requirements
- R1: `est_o` is high in the cycle after a clock edge that sampled `tone_valid_i` high with `pwr_down_i` low. It is low in the cycle after an edge that sampled `tone_valid_i` low.
- R2: A tone is accepted only when `tone_valid_i` is sampled high on PRES_TICKS consecutive edges. Counting the first such edge as edge 1, the key code is loaded on edge PRES_TICKS+1.
- R3: `dv_o` rises one clock after the code register is loaded, which is edge PRES_TICKS+2. The code is therefore already on `dout_o` one cycle before `dv_o` rises.
- R4: If early-steering drops before the presence window completes, the presence count restarts from zero. For example, two bursts of PRES_TICKS-1 edges separated by one low edge are never accepted.
- R5: While `dv_o` is high, it falls only after `est_o` has been sampled low on ABS_TICKS consecutive edges. It falls on the last of those edges. A shorter gap leaves `dv_o` high.
- R6: The latched code changes only on acceptance from the idle state. It is held after `dv_o` falls. It is also held while new tones arrive during a valid period.
- R7: The key code is a function of row (0..3) and column (0..3). For row r<3 and column c<3 the code is 3r+c+1. Row 3 gives 11, 10 and 12 for columns 0, 1 and 2. Column 3 gives 13, 14 and 15 for rows 0, 1 and 2, and 0 for row 3.
- R8: `dout_en_o` equals `oe_i`. When `oe_i` is low, `dout_o` reads 0 and the latched code is not disturbed. When `oe_i` is high, `dout_o` shows the latched code.
- R9: An edge that samples `pwr_down_i` high clears `est_o`, `dv_o` and both guard counts, and keeps the latched code. While `pwr_down_i` stays high, `tone_valid_i` has no effect.
- R10: After reset, `est_o` and `dv_o` are low and the latched code is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| tone_valid_i | input | 1 | Classifier reports a valid tone pair |
| row_i | input | 2 | Low-group (row) index 0..3 |
| col_i | input | 2 | High-group (column) index 0..3 |
| oe_i | input | 1 | Data output enable; the host ties it high by default |
| pwr_down_i | input | 1 | Power-down; the host ties it low by default |
| est_o | output | 1 | Early-steering signal |
| dout_o | output | 4 | Latched key code, 0 while disabled |
| dout_en_o | output | 1 | Drive-enable flag for the data pads |
| dv_o | output | 1 | Data-valid strobe |

## Verification
The bench builds the block with PRES_TICKS=5 and ABS_TICKS=4. With these short windows, every one of the 16 row/column pairs can be swept against every burst length from 1 to 8 edges in a few thousand cycles. That sweep covers the lengths just below, at and above the presence window, and every cycle of each run is compared against arithmetic predictions of `est_o`, `dv_o` and `dout_o`. The same small values also put within reach the gap of ABS_TICKS-1 edges that must not release, the split burst that must restart the presence count, and the power-down and output-enable cases.

// File: rtl/dtmf_steer_pkg.sv
package dtmf_steer_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_LOAD  = 2'd1,
    ST_VALID = 2'd2
  } steer_state_e;

  localparam int unsigned IDX_W  = 2;
  localparam int unsigned CODE_W = 4;

endpackage

// File: rtl/dtmf_guard_timer.sv
module dtmf_guard_timer #(
  parameter int unsigned LIMIT = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_i,
  output logic done_o
);
  localparam int unsigned CNT_W = (LIMIT > 1) ? $clog2(LIMIT) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(LIMIT - 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             hit;

  assign hit    = (cnt_q == LAST);
  assign done_o = run_i & hit;

  always_comb begin
    if (!run_i)   cnt_d = '0;
    else if (hit) cnt_d = cnt_q;
    else          cnt_d = cnt_q + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/dtmf_key_encoder.sv
module dtmf_key_encoder
  import dtmf_steer_pkg::*;
(
  input  logic [IDX_W-1:0]  row_i,
  input  logic [IDX_W-1:0]  col_i,
  output logic [CODE_W-1:0] code_o
);
  always_comb begin
    if (col_i == 2'd3) begin
      code_o = CODE_W'(13) + CODE_W'(row_i);
    end else if (row_i == 2'd3) begin
      case (col_i)
        2'd0:    code_o = 4'd11;
        2'd1:    code_o = 4'd10;
        default: code_o = 4'd12;
      endcase
    end else begin
      code_o = CODE_W'(3) * CODE_W'(row_i) + CODE_W'(col_i) + CODE_W'(1);
    end
  end
endmodule

// File: rtl/dtmf_steer_ctrl.sv
module dtmf_steer_ctrl
  import dtmf_steer_pkg::*;
#(
  parameter int unsigned PRES_TICKS = 100000,
  parameter int unsigned ABS_TICKS  = 100000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tone_valid_i,
  input  logic [IDX_W-1:0]  row_i,
  input  logic [IDX_W-1:0]  col_i,
  input  logic              oe_i,
  input  logic              pwr_down_i,
  output logic              est_o,
  output logic [CODE_W-1:0] dout_o,
  output logic              dout_en_o,
  output logic              dv_o
);
  localparam int unsigned SYNC_STAGES = 2;

  // reset release synchronizer
  logic [SYNC_STAGES-1:0] rst_pipe_q;
  logic                   rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= '0;
    else        rst_pipe_q <= {rst_pipe_q[SYNC_STAGES-2:0], 1'b1};
  end
  assign rst_sync_n = rst_pipe_q[SYNC_STAGES-1];

  // state
  steer_state_e      state_q, state_d;
  logic              est_q, est_d;
  logic [IDX_W-1:0]  row_q, col_q;
  logic              idx_en;
  logic [CODE_W-1:0] code_q, code_d, enc_code;
  logic              code_en;
  logic              pres_run, pres_done;
  logic              abs_run, abs_done;
  logic              in_load;

  assign est_d  = tone_valid_i & ~pwr_down_i;
  assign idx_en = est_d;

  assign pres_run = est_q  & (state_q == ST_IDLE)  & ~pwr_down_i;
  assign abs_run  = ~est_q & (state_q == ST_VALID) & ~pwr_down_i;

  dtmf_guard_timer #(.LIMIT(PRES_TICKS)) i_pres_timer (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .run_i  (pres_run),
    .done_o (pres_done)
  );

  dtmf_guard_timer #(.LIMIT(ABS_TICKS)) i_abs_timer (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .run_i  (abs_run),
    .done_o (abs_done)
  );

  dtmf_key_encoder i_encoder (
    .row_i  (row_q),
    .col_i  (col_q),
    .code_o (enc_code)
  );

  always_comb begin
    state_d = state_q;
    code_en = 1'b0;
    code_d  = enc_code;
    if (pwr_down_i) begin
      state_d = ST_IDLE;
    end else begin
      case (state_q)
        ST_IDLE: if (pres_done) begin
          state_d = ST_LOAD;
          code_en = 1'b1;
        end
        ST_LOAD:  state_d = ST_VALID;
        ST_VALID: if (abs_done) state_d = ST_IDLE;
        default:  state_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      state_q <= ST_IDLE;
      est_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      est_q   <= est_d;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      row_q <= '0;
      col_q <= '0;
    end else if (idx_en) begin
      row_q <= row_i;
      col_q <= col_i;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n)  code_q <= '0;
    else if (code_en) code_q <= code_d;
  end

  assign in_load   = (state_q == ST_LOAD);
  assign est_o     = est_q;
  assign dv_o      = (state_q == ST_VALID);
  assign dout_en_o = oe_i;
  assign dout_o    = oe_i ? code_q : '0;
endmodule

// File: rtl/dtmf_steer_chk.sv
module dtmf_steer_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       tone_valid_i,
  input logic       pwr_down_i,
  input logic       est_o,
  input logic       dv_o,
  input logic [3:0] code_q,
  input logic       in_load
);
  // R1: early-steering is never high without a sampled tone flag
  a_r1_est_needs_tone: assert property (@(posedge clk) disable iff (!rst_n)
    est_o |-> $past(tone_valid_i));

  // R3: data-valid follows the load cycle
  a_r3_dv_after_load: assert property (@(posedge clk) disable iff (!rst_n)
    (in_load && !pwr_down_i) |=> dv_o);

  // R5: data-valid falls only after steering was low, or on power-down
  a_r5_fall_on_absence: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dv_o) |-> ($past(!est_o) || $past(pwr_down_i)));

  // R6: the code does not move during a valid period
  a_r6_code_held: assert property (@(posedge clk) disable iff (!rst_n)
    dv_o |=> $stable(code_q));

  // R9: power-down clears steering and data-valid
  a_r9_pd_clears: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_down_i |=> (!est_o && !dv_o));
endmodule

bind dtmf_steer_ctrl dtmf_steer_chk i_chk (
  .clk          (clk),
  .rst_n        (rst_sync_n),
  .tone_valid_i (tone_valid_i),
  .pwr_down_i   (pwr_down_i),
  .est_o        (est_o),
  .dv_o         (dv_o),
  .code_q       (code_q),
  .in_load      (in_load)
);

// File: tb/test_dtmf_steer_ctrl.sv
module test_dtmf_steer_ctrl;
  localparam int PRES = 5;
  localparam int ABS  = 4;

  logic       clk;
  logic       rst_n;
  logic       tone_valid_i;
  logic [1:0] row_i, col_i;
  logic       oe_i, pwr_down_i;
  logic       est_o, dout_en_o, dv_o;
  logic [3:0] dout_o;

  int n_checks;
  int n_fail;
  int cycles;
  logic [3:0] prev_code;

  dtmf_steer_ctrl #(.PRES_TICKS(PRES), .ABS_TICKS(ABS)) i_dtmf_steer_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .tone_valid_i (tone_valid_i),
    .row_i        (row_i),
    .col_i        (col_i),
    .oe_i         (oe_i),
    .pwr_down_i   (pwr_down_i),
    .est_o        (est_o),
    .dout_o       (dout_o),
    .dout_en_o    (dout_en_o),
    .dv_o         (dv_o)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  function automatic logic [3:0] key_of(input int r, input int c);
    if (c == 3)      return 4'((13 + r) % 16);
    else if (r == 3) return (c == 0) ? 4'd11 : (c == 1) ? 4'd10 : 4'd12;
    else             return 4'(3 * r + c + 1);
  endfunction

  task automatic check(input logic ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic finish_run();
    $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
      finish_run();
    end
  end

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // one burst of n high edges, checked on every cycle (R1, R2, R3, R5, R6, R7)
  task automatic run_key(input int r, input int c, input int n);
    logic [3:0] code;
    bit acc;
    int s, total;
    code  = key_of(r, c);
    acc   = (n >= PRES);
    s     = (n + 2 > PRES + 3) ? n + 2 : PRES + 3;
    total = n + PRES + ABS + 6;
    row_i = 2'(r);
    col_i = 2'(c);
    tone_valid_i = 1'b1;
    for (int k = 1; k <= total; k++) begin
      bit exp_dv;
      logic [3:0] exp_code;
      @(negedge clk);
      exp_dv   = acc && (k >= PRES + 2) && (k < s + ABS - 1);
      exp_code = (acc && k >= PRES + 1) ? code : prev_code;
      check(est_o == (k <= n), "R1 est", int'(est_o), int'(k <= n));
      check(dv_o == exp_dv, acc ? "R3/R5 dv timing" : "R2 short burst rejected",
            int'(dv_o), int'(exp_dv));
      check(dout_o == exp_code, "R7/R6 code", int'(dout_o), int'(exp_code));
      if (k == n) tone_valid_i = 1'b0;
    end
    if (acc) prev_code = code;
  endtask

  initial begin
    n_checks = 0; n_fail = 0; cycles = 0;
    rst_n = 1'b0; tone_valid_i = 1'b0; row_i = '0; col_i = '0;
    oe_i = 1'b1; pwr_down_i = 1'b0; prev_code = 4'd0;
    idle(3);
    rst_n = 1'b1;
    idle(4);
    // R10 reset state
    check(est_o == 1'b0, "R10 est", int'(est_o), 0);
    check(dv_o == 1'b0, "R10 dv", int'(dv_o), 0);
    check(dout_o == 4'd0, "R10 code", int'(dout_o), 0);
    check(dout_en_o == 1'b1, "R8 enable", int'(dout_en_o), 1);

    // sweep: every key against burst lengths 1..PRES+3 (R2, R3, R5, R7)
    for (int r = 0; r < 4; r++)
      for (int c = 0; c < 4; c++)
        for (int n = 1; n <= PRES + 3; n++)
          run_key(r, c, n);

    // R5/R6: short gap keeps dv and code; second key ignored
    row_i = 2'd0; col_i = 2'd1; tone_valid_i = 1'b1;   // code 2
    idle(PRES + 3);
    tone_valid_i = 1'b0;
    idle(ABS - 1);
    row_i = 2'd2; col_i = 2'd2; tone_valid_i = 1'b1;   // code 9
    idle(1);
    check(dv_o == 1'b1, "R5 gap below window keeps dv", int'(dv_o), 1);
    idle(PRES + 3);
    check(dout_o == 4'd2, "R6 code held during valid", int'(dout_o), 2);
    tone_valid_i = 1'b0;
    idle(1);
    check(dv_o == 1'b1, "R5 dv before absence window", int'(dv_o), 1);
    idle(ABS + 3);
    check(dv_o == 1'b0, "R5 released", int'(dv_o), 0);
    check(dout_o == 4'd2, "R6 code held after release", int'(dout_o), 2);

    // R4: split burst restarts presence count
    row_i = 2'd1; col_i = 2'd1; tone_valid_i = 1'b1;
    idle(PRES - 1);
    tone_valid_i = 1'b0;
    idle(1);
    tone_valid_i = 1'b1;
    idle(PRES - 1);
    tone_valid_i = 1'b0;
    idle(PRES + 4);
    check(dv_o == 1'b0, "R4 split burst no dv", int'(dv_o), 0);
    check(dout_o == 4'd2, "R4 split burst no load", int'(dout_o), 2);

    // R8: output enable low
    row_i = 2'd3; col_i = 2'd2; tone_valid_i = 1'b1;   // code 12
    oe_i = 1'b0;
    idle(PRES + 3);
    check(dout_en_o == 1'b0, "R8 enable low", int'(dout_en_o), 0);
    check(dout_o == 4'd0, "R8 bus zero when disabled", int'(dout_o), 0);
    check(dv_o == 1'b1, "R8 detection unaffected", int'(dv_o), 1);
    oe_i = 1'b1;
    #1;
    check(dout_o == 4'd12, "R8 code visible again", int'(dout_o), 12);

    // R9: power-down during valid
    pwr_down_i = 1'b1;
    idle(1);
    check(est_o == 1'b0, "R9 est cleared", int'(est_o), 0);
    check(dv_o == 1'b0, "R9 dv cleared", int'(dv_o), 0);
    check(dout_o == 4'd12, "R9 code kept", int'(dout_o), 12);
    row_i = 2'd0; col_i = 2'd0;
    idle(3 * PRES);
    check(dv_o == 1'b0, "R9 tone ignored dv", int'(dv_o), 0);
    check(est_o == 1'b0, "R9 tone ignored est", int'(est_o), 0);
    check(dout_o == 4'd12, "R9 tone ignored code", int'(dout_o), 12);
    // release power-down with tone still high: fresh count
    pwr_down_i = 1'b0;
    idle(PRES);
    check(dv_o == 1'b0, "R9 count restarts after power-down", int'(dv_o), 0);
    idle(2);
    check(dout_o == 4'd1, "R2 accepted after power-down", int'(dout_o), 1);
    check(dv_o == 1'b1, "R3 dv after power-down", int'(dv_o), 1);
    tone_valid_i = 1'b0;
    idle(ABS + 4);
    check(dv_o == 1'b0, "R5 final release", int'(dv_o), 0);

    finish_run();
  end
endmodule